// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Core

This block is the logic core of a pipelined synchronous SRAM that moves data in bursts of two 36-bit words. A single clock runs at beat rate. A command may be taken only on an even beat, and every accepted command moves exactly two words on two consecutive beats. The caller supplies a pair address with bit 0 left off. An internal burst counter supplies that bit, so the first word goes to the even location and the second to the odd one.

Write data comes in on the two beats after the write command. Each beat has four active-low lane enables, one for each 9-bit lane. The core writes both words into its register array once the second beat has arrived. A read that comes straight after a write to the same pair gets the new data through a forwarding path, merged lane by lane with the old contents. Read data comes back after two beats or after three beats, chosen by a latency-select input. Both the output-enable and the valid flag are high only on the beats that carry read data.

Top module: `burst_ddr_sram`

## Requirements
- R1: While reset is held and after it is released, and until a read delivers data, `rd_valid` and `rd_oe` are low and `rd_data` is zero.
- R2: The first clock edge after reset is released is an even beat, and beats alternate from then on. A command is taken only when `cmd_valid` is high on an even beat. On odd beats, and whenever `cmd_valid` is low, `cmd_write`, `cmd_addr`, the lane enables and the data have no effect on the array or on the outputs.
- R3: For pair address A, the first beat of a burst goes to word 2A and the second to word 2A+1. A read returns word 2A first and then word 2A+1.
- R4: For a write accepted at edge E, word 0 is sampled at edge E+1 and word 1 at edge E+2. The array is updated at E+2, so a read accepted at E+4 or later sees the new contents.
- R5: `wr_lane_n[i]` high on a data beat leaves bits [9i+8:9i] of that beat's word unchanged. Low writes them. Each beat has its own lane enables.
- R6: With `long_latency` low, a read accepted at edge E shows word 0 on the outputs after edge E+2 and word 1 after edge E+3.
- R7: With `long_latency` high, a read accepted at edge E shows word 0 after edge E+3 and word 1 after edge E+4.
- R8: A read accepted on the command slot right after a write to the same pair returns the write's data merged by lane enables with the earlier contents, never the stale contents. A read of a different pair in that slot is not affected.
- R9: `rd_valid` and `rd_oe` are high exactly on the beats that carry read data. Back-to-back reads give a continuous run. They drop the beat after the last data beat, which is one command slot after a NOP or write follows a read. `rd_data` is zero whenever they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, honoured on even beats only |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | ADDR_W-1 | Pair address (word address without bit 0) |
| wr_lane_n | input | 4 | Active-low lane write enables for the current data beat |
| wr_data | input | 36 | Write data for the current data beat |
| long_latency | input | 1 | 1 = three-beat read latency, 0 = two-beat |
| rd_data | output | 36 | Read data, zero when not driven |
| rd_oe | output | 1 | Output drive enable |
| rd_valid | output | 1 | Marks beats carrying read data |

## Verification
The bench targets four corner cases. The first is a read issued in the slot right after a write to the same pair: a core without forwarding would return the old words there. The second is lane enables that differ between the two beats: a core that applied one mask to both beats would corrupt one of the words. The third is the odd beat. Strobes placed there must not start a transfer, and a core that accepted them would either show extra valid beats or write junk that a later sweep reads back. The fourth is output timing. Every beat is compared for valid, enable and data in both latency modes, so data shifted by one beat, or an enable left high after a NOP, shows up at once.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int WORD_W = 36;
    localparam int LANES  = 4;
    localparam int LANE_W = WORD_W / LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    // one beat travelling down the read pipeline
    typedef struct packed {
        logic  vld;
        word_t data;
    } beat_t;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_GET0 = 2'd1,
        WR_GET1 = 2'd2
    } wr_state_e;

    // replace the lanes whose active-low enable is low
    function automatic word_t lane_merge(word_t base, word_t upd, lane_t blk_n);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (!blk_n[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/bsram_wr_capture.sv
module bsram_wr_capture
    import bsram_pkg::*;
#(
    parameter int PAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PAW-1:0] start_addr,
    input  word_t          beat_data,
    input  lane_t          beat_lane_n,
    output logic           commit,
    output logic [PAW-1:0] commit_addr,
    output word_t          first_data,
    output lane_t          first_lane_n
);

    wr_state_e      st_q;
    logic [PAW-1:0] addr_q;
    word_t          w0_q;
    lane_t          m0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WR_IDLE;
        end else begin
            unique case (st_q)
                WR_IDLE: if (start) st_q <= WR_GET0;
                WR_GET0: st_q <= WR_GET1;
                WR_GET1: st_q <= start ? WR_GET0 : WR_IDLE;
                default: st_q <= WR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (start) addr_q <= start_addr;
        if (st_q == WR_GET0) begin
            w0_q <= beat_data;
            m0_q <= beat_lane_n;
        end
    end

    assign commit       = (st_q == WR_GET1);
    assign commit_addr  = addr_q;
    assign first_data   = w0_q;
    assign first_lane_n = m0_q;

    // R4: the array update comes two edges after the write is taken
    a_r4_commit_after_two: assert property (@(posedge clk) disable iff (rst)
        $past(start, 2) |-> commit);

    // R2: no new command lands on the odd beat that carries word 0
    a_r2_no_start_mid: assert property (@(posedge clk) disable iff (rst)
        (st_q == WR_GET0) |-> !start);

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int PAW = 4
) (
    input  logic           clk,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  word_t          wd0,
    input  lane_t          wm0,
    input  word_t          wd1,
    input  lane_t          wm1,
    input  logic [PAW-1:0] raddr,
    output word_t          rd0,
    output word_t          rd1
);

    localparam int DEPTH = 2 ** (PAW + 1);

    word_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam bit             HI   = (g % 2) == 1;
        localparam logic [PAW-1:0] PAIR = PAW'(g / 2);
        word_t cell_q;
        word_t src;
        lane_t blk;

        assign src = HI ? wd1 : wd0;
        assign blk = HI ? wm1 : wm0;

        always_ff @(posedge clk) begin
            if (we && waddr == PAIR) cell_q <= lane_merge(cell_q, src, blk);
        end

        assign cells[g] = cell_q;
    end

    // burst counter: low bit starts at 0 and steps once, wrapping inside the pair
    assign rd0 = cells[{raddr, 1'b0}];
    assign rd1 = cells[{raddr, 1'b1}];

endmodule

// File: rtl/bsram_rd_pipe.sv
module bsram_rd_pipe
    import bsram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t first_w,
    input  word_t second_w,
    input  logic  long_lat,
    output logic  rd_valid,
    output logic  rd_oe,
    output word_t rdata
);

    beat_t s0_q, s1_q, s2_q, out_q;
    word_t second_q;
    logic  tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q   <= '0;
            s1_q   <= '0;
            s2_q   <= '0;
            out_q  <= '0;
            tail_q <= 1'b0;
        end else begin
            if (load)        s0_q <= beat_t'({1'b1, first_w});
            else if (tail_q) s0_q <= beat_t'({1'b1, second_q});
            else             s0_q <= '0;
            tail_q <= load;
            s1_q   <= s0_q;
            s2_q   <= s1_q;
            out_q  <= long_lat ? s2_q : s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (load) second_q <= second_w;
    end

    assign rd_valid = out_q.vld;
    assign rd_oe    = out_q.vld;
    assign rdata    = out_q.vld ? out_q.data : '0;

    // R6: short mode, first word visible after the second edge
    a_r6_short_latency: assert property (@(posedge clk) disable iff (rst)
        ($past(load, 3) && !long_lat) |-> rd_valid);

    // R7: long mode, first word visible after the third edge
    a_r7_long_latency: assert property (@(posedge clk) disable iff (rst)
        ($past(load, 4) && long_lat) |-> rd_valid);

    // R9: data beats always come in pairs
    a_r9_pair_beats: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid);

    // R1: reset clears the output side
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rd_valid && !rd_oe));

endmodule

// File: rtl/burst_ddr_sram.sv
module burst_ddr_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic                     cmd_write,
    input  logic [ADDR_W-2:0]        cmd_addr,
    input  logic [LANES-1:0]         wr_lane_n,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     long_latency,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_oe,
    output logic                     rd_valid
);

    localparam int PAW = ADDR_W - 1;

    logic           odd_q;
    logic           accept, wr_go, rd_go;
    logic           commit, fwd_hit;
    logic [PAW-1:0] commit_addr;
    word_t          cap_w0, arr_w0, arr_w1, out_w0, out_w1;
    lane_t          cap_m0;

    always_ff @(posedge clk) begin
        if (rst) odd_q <= 1'b0;
        else     odd_q <= ~odd_q;
    end

    assign accept = cmd_valid && !odd_q && !rst;
    assign wr_go  = accept && cmd_write;
    assign rd_go  = accept && !cmd_write;

    bsram_wr_capture #(.PAW(PAW)) u_wcap (
        .clk          (clk),
        .rst          (rst),
        .start        (wr_go),
        .start_addr   (cmd_addr),
        .beat_data    (wr_data),
        .beat_lane_n  (wr_lane_n),
        .commit       (commit),
        .commit_addr  (commit_addr),
        .first_data   (cap_w0),
        .first_lane_n (cap_m0)
    );

    bsram_array #(.PAW(PAW)) u_mem (
        .clk   (clk),
        .we    (commit),
        .waddr (commit_addr),
        .wd0   (cap_w0),
        .wm0   (cap_m0),
        .wd1   (wr_data),
        .wm1   (wr_lane_n),
        .raddr (cmd_addr),
        .rd0   (arr_w0),
        .rd1   (arr_w1)
    );

    // the write committing at this edge has not reached the array yet
    assign fwd_hit = commit && (commit_addr == cmd_addr);
    assign out_w0  = fwd_hit ? lane_merge(arr_w0, cap_w0, cap_m0)     : arr_w0;
    assign out_w1  = fwd_hit ? lane_merge(arr_w1, wr_data, wr_lane_n) : arr_w1;

    bsram_rd_pipe u_rpipe (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_go),
        .first_w  (out_w0),
        .second_w (out_w1),
        .long_lat (long_latency),
        .rd_valid (rd_valid),
        .rd_oe    (rd_oe),
        .rdata    (rd_data)
    );

    // R2: the array only updates on even beats
    a_r2_commit_even: assert property (@(posedge clk) disable iff (rst)
        commit |-> !odd_q);

endmodule

// File: tb/burst_ddr_sram_bench.sv
`timescale 1ns/1ps
module burst_ddr_sram_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [3:0]  cmd_addr = '0;
    logic [3:0]  wr_lane_n = 4'hF;
    logic [35:0] wr_data = '0;
    logic        long_latency = 1'b0;
    logic [35:0] rd_data;
    logic        rd_oe, rd_valid;

    burst_ddr_sram #(.ADDR_W(5)) u_burst_ddr_sram (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .wr_lane_n(wr_lane_n), .wr_data(wr_data),
        .long_latency(long_latency), .rd_data(rd_data), .rd_oe(rd_oe),
        .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [35:0] model [32];
    bit          exp_v [16];
    logic [35:0] exp_d [16];
    string       exp_t [16];
    logic [35:0] pend_d;
    logic [3:0]  pend_m;

    function automatic logic [35:0] rnd36();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[35:0];
    endfunction

    function automatic logic [35:0] apply(logic [35:0] old, logic [35:0] nw, logic [3:0] m);
        logic [35:0] r;
        r = old;
        for (int l = 0; l < 4; l++) if (m[l] == 1'b0) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic check_out();
        int i;
        logic [35:0] ed;
        i = cyc % 16;
        ed = exp_v[i] ? exp_d[i] : 36'd0;
        n_chk++;
        if (rd_valid !== exp_v[i] || rd_oe !== exp_v[i] || rd_data !== ed) begin
            n_fail++;
            $display("FAIL %s cyc %0d: valid=%b oe=%b data=%h, expected valid=%b oe=%b data=%h",
                     exp_t[i], cyc, rd_valid, rd_oe, rd_data, exp_v[i], exp_v[i], ed);
        end
        exp_v[i] = 1'b0;
        exp_d[i] = '0;
        exp_t[i] = "R9";
    endtask

    task automatic beat(bit cv, bit wr, logic [3:0] a, logic [35:0] d, logic [3:0] m);
        check_out();
        cmd_valid = cv;
        cmd_write = wr;
        cmd_addr  = a;
        wr_data   = d;
        wr_lane_n = m;
        @(negedge clk);
    endtask

    // one command slot: even beat (command + previous word 1), odd beat (word 0)
    task automatic slot(bit cv, bit wr, logic [3:0] a, logic [35:0] d0, logic [3:0] m0,
                        logic [35:0] d1, logic [3:0] m1, string tag, bit junk);
        int e, l;
        logic [3:0] ja;
        if (cv && !wr) begin
            e = cyc + 1;
            l = long_latency ? 3 : 2;
            exp_v[(e+l) % 16] = 1'b1; exp_d[(e+l) % 16] = model[{a, 1'b0}]; exp_t[(e+l) % 16] = tag;
            exp_v[(e+l+1) % 16] = 1'b1; exp_d[(e+l+1) % 16] = model[{a, 1'b1}]; exp_t[(e+l+1) % 16] = tag;
        end
        if (cv && wr) begin
            model[{a, 1'b0}] = apply(model[{a, 1'b0}], d0, m0);
            model[{a, 1'b1}] = apply(model[{a, 1'b1}], d1, m1);
        end
        beat(cv, wr, a, pend_d, pend_m);
        ja = ~a;
        if (cv && wr) beat(junk, junk ? 1'($urandom()) : 1'b0, ja, d0, m0);
        else          beat(junk, junk ? 1'($urandom()) : 1'b0, ja, rnd36(), 4'h0);
        if (cv && wr) begin
            pend_d = d1; pend_m = m1;
        end else begin
            pend_d = rnd36(); pend_m = 4'($urandom());
        end
    endtask

    task automatic wr(logic [3:0] a, logic [35:0] d0, logic [3:0] m0, logic [35:0] d1, logic [3:0] m1);
        slot(1'b1, 1'b1, a, d0, m0, d1, m1, "R9", 1'b0);
    endtask

    task automatic rd(logic [3:0] a, string tag);
        slot(1'b1, 1'b0, a, '0, 4'hF, '0, 4'hF, tag, 1'b0);
    endtask

    task automatic nop();
        slot(1'b0, 1'($urandom()), 4'($urandom()), '0, 4'hF, '0, 4'hF, "R9", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_t[i] = "R9"; end
        for (int i = 0; i < 32; i++) model[i] = '0;
        pend_d = rnd36();
        pend_m = 4'h0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet under reset
        n_chk++;
        if (rd_valid !== 1'b0 || rd_oe !== 1'b0 || rd_data !== 36'd0) begin
            n_fail++;
            $display("FAIL R1: valid=%b oe=%b data=%h, expected 0 0 0", rd_valid, rd_oe, rd_data);
        end
        rst = 1'b0;

        // R3: fill every pair, read all back to back
        for (int a = 0; a < 16; a++) wr(4'(a), rnd36(), 4'h0, rnd36(), 4'h0);
        nop();
        for (int a = 0; a < 16; a++) rd(4'(a), "R3");
        repeat (3) nop();

        // R5: distinct lane masks per beat
        for (int a = 0; a < 16; a++) wr(4'(a), rnd36(), 4'(a), rnd36(), ~4'(a));
        nop();
        for (int a = 0; a < 16; a++) rd(4'(a), "R5");
        repeat (3) nop();

        // R4: write, one gap slot, read back
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), rnd36(), 4'($urandom()), rnd36(), 4'($urandom()));
            nop();
            rd(4'(a), "R4");
        end
        repeat (3) nop();

        // R8: read right after write, same pair and a neighbouring pair
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), rnd36(), 4'($urandom()), rnd36(), 4'($urandom()));
            rd(4'(a), "R8");
            wr(4'(a), rnd36(), 4'($urandom()), rnd36(), 4'($urandom()));
            rd(4'(a + 1), "R8");
        end
        repeat (3) nop();

        // R6 and R9: short latency with gaps, read followed by write
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), "R6");
            if (a % 2 == 0) nop();
            else wr(4'(a), rnd36(), 4'h0, rnd36(), 4'h0);
        end
        repeat (3) nop();

        // R7: long latency, back to back, gaps and forwarding
        long_latency = 1'b1;
        for (int a = 0; a < 16; a++) rd(4'(a), "R7");
        repeat (3) nop();
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), rnd36(), 4'($urandom()), rnd36(), 4'($urandom()));
            rd(4'(a), "R7");
            nop();
        end
        repeat (3) nop();
        long_latency = 1'b0;

        // R2: strobes on odd beats and deselected slots carry junk
        for (int a = 0; a < 16; a++) begin
            slot(1'b0, 1'b1, 4'(a), rnd36(), 4'h0, rnd36(), 4'h0, "R2", 1'b1);
            slot(1'b1, 1'b1, 4'(a), rnd36(), 4'($urandom()), rnd36(), 4'($urandom()), "R2", 1'b1);
            slot(1'b1, 1'b0, 4'(a + 7), '0, 4'hF, '0, 4'hF, "R2", 1'b1);
        end
        repeat (3) nop();
        for (int a = 0; a < 16; a++) rd(4'(a), "R2");
        repeat (4) nop();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule